// File: doc/BRIEF.md
# SPI Biopotential Front-End Mock

This block stands in for an eight-channel, 24-bit biopotential converter so that a host-side controller can be exercised without the real device. It is an SPI slave (mode 0: MOSI sampled on the rising SCLK edge, MISO changed on the falling edge, chip select active low). The slave holds a small configuration register file and decodes one opcode per chip-select window. The opcodes cover single and burst register access, standby, wakeup, register reset, and a continuous sample stream.

In streaming mode the block starts a conversion period every `SAMPLE_DIV` system clocks and signals each new frame on an active-low ready line. The host then clocks out a fixed 27-byte frame. Sample words come from a frame counter, not from any analog path. The default divider gives 500 frames per second at a 100 MHz system clock. Standby and wakeup each hold the block deaf to commands for a parameterised number of cycles. SPI inputs are resynchronised into the system clock domain, so SCLK must run well below the system clock (half period of at least six system clocks).

Top module: `ecg_spi_mock`

## Requirements
- R1: After reset, dataReadyN is 1, miso is 0 while csN is high, and register i (0..25) reads 8'hA0 + i.
- R2: A read transaction sends an opcode with bits [7:5] = 3'b001 and start address in bits [4:0], then a count byte holding (number of registers - 1). MISO carries 8'h00 during the opcode and count bytes and register contents in the bytes that follow.
- R3: A write transaction sends opcode bits [7:5] = 3'b010 with start address in bits [4:0], then a count byte (number - 1), then one data byte per register. The data bytes land in consecutive registers.
- R4: A burst read returns consecutive registers starting at the start address, one per byte, with 8'h00 for bytes after the requested count.
- R5: Addresses 26 to 31 hold nothing: writes to them are dropped and reads return 8'h00.
- R6: Opcode 8'h06 returns every register to its reset value.
- R7: Opcode 8'h10 starts streaming. dataReadyN falls once per SAMPLE_DIV clocks, the first fall coming at most SAMPLE_DIV clocks after the command.
- R8: dataReadyN stays low after csN falls and returns to 1 at the first rising SCLK edge of the window.
- R9: Each chip-select window in streaming mode shifts out a frame snapshotted at csN fall. Bytes 0..2 are 8'hC0, 8'h00, 8'h00. Channel c (0..7) then occupies bytes 3+3c..5+3c as {c, n[15:8], n[7:0]}, where n counts conversions since the start command (first frame n = 1). Bytes from 27 on read 8'h00.
- R10: Opcode 8'h11 as the first byte of a window stops streaming, and dataReadyN then stays 1. Register commands issued while streaming are ignored.
- R11: Opcode 8'h04 enters standby. For SLEEP_DLY clocks every command is ignored, and afterwards only 8'h02 is accepted. That wakeup is followed by WAKE_DLY clocks in which every command is ignored, after which normal commands work again.
- R12: Opcodes other than the listed ones are ignored, together with all bytes that follow in the same window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock (idle low) |
| mosi | input | 1 | Host-to-slave serial data |
| miso | output | 1 | Slave-to-host serial data, 0 when not selected |
| dataReadyN | output | 1 | Active-low new-frame indication |

## Verification
A corrupted register file or address pointer shows up on MISO in the very next read, as a byte that differs from the arithmetic default or from the last written pattern. A pointer off by one shifts every byte of a burst. A wrong mode or delay counter shows as a write that takes effect when it should not, or is lost when it should land, and read-back exposes it at once. A bad conversion timer shows as a ready-fall spacing other than SAMPLE_DIV, within two sample periods, and a bad frame counter shows in the low channel bytes of the next frame.

// File: rtl/ecg_mock_pkg.sv
package ecg_mock_pkg;
  localparam int ADDR_W = 5;

  localparam logic [7:0] OP_WAKEUP  = 8'h02;
  localparam logic [7:0] OP_STANDBY = 8'h04;
  localparam logic [7:0] OP_RESET   = 8'h06;
  localparam logic [7:0] OP_START   = 8'h10;
  localparam logic [7:0] OP_STOP    = 8'h11;
  localparam logic [2:0] OP_RD_HI   = 3'b001;
  localparam logic [2:0] OP_WR_HI   = 3'b010;

  localparam logic [7:0] REG_BASE   = 8'hA0;
  localparam logic [7:0] STATUS_HI  = 8'hC0;

  typedef enum logic [2:0] {MD_IDLE, MD_STREAM, MD_SLEEPING, MD_ASLEEP, MD_WAKING} mode_e;
  typedef enum logic [1:0] {TX_ZERO, TX_REG, TX_FRAME} txSrc_e;
  typedef enum logic [1:0] {PH_OP, PH_CNT, PH_DATA, PH_SKIP} phase_e;

  typedef struct packed {
    logic regWrite;
    logic regRestore;
    logic sampleStep;
    logic sampleClear;
    logic snapFrame;
  } dpStrobe_t;
endpackage

// File: rtl/ecg_mock_dp.sv
module ecg_mock_dp
  import ecg_mock_pkg::*;
#(
  parameter int NUM_REGS     = 26,
  parameter int NUM_CH       = 8,
  parameter int SAMPLE_BITS  = 24,
  parameter int STATUS_BYTES = 3,
  parameter int IDX_W        = 16,
  parameter int FIDX_W       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  txSrc_e            txSrc,
  input  logic [FIDX_W-1:0] frameIdx,
  output logic              csActive,
  output logic              csFall,
  output logic              sclkRise,
  output logic              byteValid,
  output logic [7:0]        rxByte
);
  localparam int SAMPLE_BYTES = SAMPLE_BITS / 8;

  logic [1:0] csSync;
  logic [2:0] sclkSync;
  logic [1:0] mosiSync;
  logic       csPrev, csFallD, byteEnd, sclkFall;
  logic [2:0] bitCnt;
  logic [7:0] rxShift, txShift, txNext, regRd, frameByte;
  logic [7:0] regFile [NUM_REGS];
  logic [IDX_W-1:0] sampleCount, snap;

  // input resynchronisation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= 2'b11;
      sclkSync <= 3'b000;
      mosiSync <= 2'b00;
      csPrev   <= 1'b0;
    end else begin
      csSync   <= {csSync[0], csN};
      sclkSync <= {sclkSync[1:0], sclk};
      mosiSync <= {mosiSync[0], mosi};
      csPrev   <= csActive;
    end
  end

  assign csActive = ~csSync[1];
  assign csFall   = csActive & ~csPrev;
  assign sclkRise = csActive & sclkSync[1] & ~sclkSync[2];
  assign sclkFall = csActive & ~sclkSync[1] & sclkSync[2];

  // shift engine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      rxShift   <= '0;
      rxByte    <= '0;
      byteValid <= 1'b0;
      byteEnd   <= 1'b0;
      txShift   <= '0;
      csFallD   <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      csFallD   <= csFall;
      if (!csActive) begin
        bitCnt  <= '0;
        byteEnd <= 1'b0;
        txShift <= '0;
      end else begin
        if (sclkRise) begin
          rxShift <= {rxShift[6:0], mosiSync[1]};
          bitCnt  <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            byteValid <= 1'b1;
            rxByte    <= {rxShift[6:0], mosiSync[1]};
            byteEnd   <= 1'b1;
          end
        end
        if (csFallD) begin
          txShift <= txNext;
        end else if (sclkFall) begin
          if (byteEnd) begin
            txShift <= txNext;
            byteEnd <= 1'b0;
          end else begin
            txShift <= {txShift[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso = csActive & txShift[7];

  // register file, one slice per address
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regFile[i] <= 8'(REG_BASE + i);
      end else if (strobe.regRestore) begin
        regFile[i] <= 8'(REG_BASE + i);
      end else if (strobe.regWrite && regAddr == ADDR_W'(i)) begin
        regFile[i] <= rxByte;
      end
    end
  end

  always_comb begin
    regRd = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (regAddr == ADDR_W'(i)) regRd = regFile[i];
    end
  end

  // conversion counter and window snapshot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCount <= '0;
      snap        <= '0;
    end else begin
      if (strobe.sampleClear)     sampleCount <= '0;
      else if (strobe.sampleStep) sampleCount <= sampleCount + IDX_W'(1);
      if (strobe.snapFrame)       snap <= sampleCount;
    end
  end

  function automatic logic [7:0] chanByte(input int ch, input int k, input logic [IDX_W-1:0] idx);
    logic [SAMPLE_BITS-1:0] word;
    word = {(SAMPLE_BITS-IDX_W)'(ch), idx};
    return word[8*(SAMPLE_BYTES-1-k) +: 8];
  endfunction

  always_comb begin
    frameByte = '0;
    if (frameIdx == '0) frameByte = STATUS_HI;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int k = 0; k < SAMPLE_BYTES; k++) begin
        if (frameIdx == FIDX_W'(STATUS_BYTES + ch*SAMPLE_BYTES + k))
          frameByte = chanByte(ch, k, snap);
      end
    end
  end

  always_comb begin
    unique case (txSrc)
      TX_REG:   txNext = regRd;
      TX_FRAME: txNext = frameByte;
      default:  txNext = 8'h00;
    endcase
  end

  // R2: a received byte is only reported right after a sampling edge
  p_byte_after_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(sclkRise));

  // R9: frame content is frozen inside a window
  p_snap_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csActive && !strobe.snapFrame) |=> $stable(snap));
endmodule

// File: rtl/ecg_mock_ctrl.sv
module ecg_mock_ctrl
  import ecg_mock_pkg::*;
#(
  parameter int SAMPLE_DIV  = 200000,
  parameter int SLEEP_DLY   = 1000,
  parameter int WAKE_DLY    = 1000,
  parameter int FRAME_BYTES = 27,
  parameter int FIDX_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              csFall,
  input  logic              sclkRise,
  input  logic              byteValid,
  input  logic [7:0]        rxByte,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] regAddr,
  output txSrc_e            txSrc,
  output logic [FIDX_W-1:0] frameIdx,
  output logic              dataReadyN
);
  localparam int TMR_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int DLY_MAX = (SLEEP_DLY > WAKE_DLY) ? SLEEP_DLY : WAKE_DLY;
  localparam int DLY_W = $clog2(DLY_MAX + 1);

  mode_e             mode;
  phase_e            phase;
  logic              isRead, isWrite;
  logic [ADDR_W-1:0] ptr;
  logic [8:0]        left;
  logic [TMR_W-1:0]  sampleTmr;
  logic [DLY_W-1:0]  delayCnt;

  logic opValid, isRdOp, isWrOp, tick;
  logic doStart, doStop, doReset, doStandby, doWake, doRegOp;

  assign opValid   = byteValid && phase == PH_OP;
  assign isRdOp    = rxByte[7:5] == OP_RD_HI;
  assign isWrOp    = rxByte[7:5] == OP_WR_HI;
  assign doStart   = opValid && mode == MD_IDLE && rxByte == OP_START;
  assign doStop    = opValid && mode == MD_STREAM && rxByte == OP_STOP;
  assign doReset   = opValid && (mode == MD_IDLE || mode == MD_STREAM) && rxByte == OP_RESET;
  assign doStandby = opValid && (mode == MD_IDLE || mode == MD_STREAM) && rxByte == OP_STANDBY;
  assign doWake    = opValid && mode == MD_ASLEEP && rxByte == OP_WAKEUP;
  assign doRegOp   = opValid && mode == MD_IDLE && (isRdOp || isWrOp);
  assign tick      = mode == MD_STREAM && sampleTmr == TMR_W'(SAMPLE_DIV - 1);

  always_comb begin
    strobe.regWrite    = byteValid && phase == PH_DATA && isWrite && left != '0;
    strobe.regRestore  = doReset;
    strobe.sampleStep  = tick;
    strobe.sampleClear = doStart;
    strobe.snapFrame   = csFall && mode == MD_STREAM;
  end

  assign regAddr = ptr;

  // transaction sequencing within one chip-select window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_OP;
      isRead   <= 1'b0;
      isWrite  <= 1'b0;
      ptr      <= '0;
      left     <= '0;
      txSrc    <= TX_ZERO;
      frameIdx <= '0;
    end else if (!csActive) begin
      phase    <= PH_OP;
      isRead   <= 1'b0;
      isWrite  <= 1'b0;
      txSrc    <= TX_ZERO;
      frameIdx <= '0;
    end else begin
      if (csFall && mode == MD_STREAM) txSrc <= TX_FRAME;
      if (byteValid) begin
        if (txSrc == TX_FRAME) begin
          if (frameIdx == FIDX_W'(FRAME_BYTES - 1)) txSrc <= TX_ZERO;
          frameIdx <= frameIdx + FIDX_W'(1);
        end
        unique case (phase)
          PH_OP: begin
            if (doRegOp) begin
              phase   <= PH_CNT;
              isRead  <= isRdOp;
              isWrite <= isWrOp;
              ptr     <= rxByte[ADDR_W-1:0];
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_CNT: begin
            phase <= PH_DATA;
            left  <= {1'b0, rxByte} + 9'd1;
            if (isRead) txSrc <= TX_REG;
          end
          PH_DATA: begin
            if (left != '0) begin
              ptr  <= ptr + ADDR_W'(1);
              left <= left - 9'd1;
              if (left == 9'd1) txSrc <= TX_ZERO;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // operating mode, conversion timer and power-state delays
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MD_IDLE;
      sampleTmr <= '0;
      delayCnt  <= '0;
    end else begin
      unique case (mode)
        MD_IDLE: begin
          if (doStart) begin
            mode      <= MD_STREAM;
            sampleTmr <= '0;
          end else if (doStandby) begin
            mode     <= MD_SLEEPING;
            delayCnt <= DLY_W'(SLEEP_DLY - 1);
          end
        end
        MD_STREAM: begin
          if (doStop || doReset) begin
            mode <= MD_IDLE;
          end else if (doStandby) begin
            mode     <= MD_SLEEPING;
            delayCnt <= DLY_W'(SLEEP_DLY - 1);
          end else begin
            sampleTmr <= tick ? '0 : sampleTmr + TMR_W'(1);
          end
        end
        MD_SLEEPING: begin
          if (delayCnt == '0) mode <= MD_ASLEEP;
          else                delayCnt <= delayCnt - DLY_W'(1);
        end
        MD_ASLEEP: begin
          if (doWake) begin
            mode     <= MD_WAKING;
            delayCnt <= DLY_W'(WAKE_DLY - 1);
          end
        end
        MD_WAKING: begin
          if (delayCnt == '0) mode <= MD_IDLE;
          else                delayCnt <= delayCnt - DLY_W'(1);
        end
        default: mode <= MD_IDLE;
      endcase
    end
  end

  // ready line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReadyN <= 1'b1;
    end else if (mode != MD_STREAM || doStop || doReset || doStandby) begin
      dataReadyN <= 1'b1;
    end else if (tick) begin
      dataReadyN <= 1'b0;
    end else if (sclkRise) begin
      dataReadyN <= 1'b1;
    end
  end

  // R7: ready is only ever asserted while streaming
  p_ready_only_stream_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dataReadyN |-> mode == MD_STREAM);

  // R9: frame byte index never runs past the frame while the frame is the source
  p_frame_idx_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    txSrc == TX_FRAME |-> frameIdx < FIDX_W'(FRAME_BYTES));

  // R10: register writes happen only in the idle mode
  p_write_idle_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.regWrite |-> mode == MD_IDLE);

  // R11: standby dwell is not cut short
  p_sleep_dwell_r11: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MD_SLEEPING && delayCnt != '0) |=> mode == MD_SLEEPING);
endmodule

// File: rtl/ecg_spi_mock.sv
module ecg_spi_mock
  import ecg_mock_pkg::*;
#(
  parameter int NUM_REGS     = 26,
  parameter int NUM_CH       = 8,
  parameter int SAMPLE_BITS  = 24,
  parameter int STATUS_BYTES = 3,
  parameter int SAMPLE_DIV   = 200000,
  parameter int SLEEP_DLY    = 1000,
  parameter int WAKE_DLY     = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic mosi,
  output logic miso,
  output logic dataReadyN
);
  localparam int FRAME_BYTES = STATUS_BYTES + NUM_CH * (SAMPLE_BITS / 8);
  localparam int FIDX_W      = $clog2(FRAME_BYTES + 1);
  localparam int IDX_W       = 16;

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] regAddr;
  txSrc_e            txSrc;
  logic [FIDX_W-1:0] frameIdx;
  logic              csActive, csFall, sclkRise, byteValid;
  logic [7:0]        rxByte;

  ecg_mock_dp #(
    .NUM_REGS(NUM_REGS), .NUM_CH(NUM_CH), .SAMPLE_BITS(SAMPLE_BITS),
    .STATUS_BYTES(STATUS_BYTES), .IDX_W(IDX_W), .FIDX_W(FIDX_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso),
    .strobe(strobe), .regAddr(regAddr), .txSrc(txSrc), .frameIdx(frameIdx),
    .csActive(csActive), .csFall(csFall), .sclkRise(sclkRise),
    .byteValid(byteValid), .rxByte(rxByte)
  );

  ecg_mock_ctrl #(
    .SAMPLE_DIV(SAMPLE_DIV), .SLEEP_DLY(SLEEP_DLY), .WAKE_DLY(WAKE_DLY),
    .FRAME_BYTES(FRAME_BYTES), .FIDX_W(FIDX_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .csFall(csFall),
    .sclkRise(sclkRise), .byteValid(byteValid), .rxByte(rxByte),
    .strobe(strobe), .regAddr(regAddr), .txSrc(txSrc), .frameIdx(frameIdx),
    .dataReadyN(dataReadyN)
  );
endmodule

// File: tb/test_ecg_spi_mock.sv
module test_ecg_spi_mock;
  localparam int NREG = 26;
  localparam int DIV  = 4000;
  localparam int SLP  = 1000;
  localparam int WAK  = 1000;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, dataReadyN;

  always #2 clk = ~clk;

  ecg_spi_mock #(.SAMPLE_DIV(DIV), .SLEEP_DLY(SLP), .WAKE_DLY(WAK)) i_ecg_spi_mock (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .miso(miso), .dataReadyN(dataReadyN)
  );

  int nChecks = 0, nFail = 0, cyc = 0;
  logic [7:0] txBuf [64];
  logic [7:0] rxBuf [64];
  logic [7:0] expReg [32];
  logic drdyBefore, drdyAfter;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  task automatic spiXfer(input int n);
    @(negedge clk);
    csN = 1'b0;
    repeat (2*HALF) @(negedge clk);
    drdyBefore = dataReadyN;
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = txBuf[b][i];
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        rxBuf[b][i] = miso;
        repeat (HALF) @(negedge clk);
        if (b == 0 && i == 7) drdyAfter = dataReadyN;
        sclk = 1'b0;
      end
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    mosi = 1'b0;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic sendOp(input logic [7:0] op);
    txBuf[0] = op;
    spiXfer(1);
  endtask

  task automatic readRegs(input int start, input int cnt);
    txBuf[0] = 8'h20 | 8'(start);
    txBuf[1] = 8'(cnt - 1);
    for (int i = 0; i < cnt; i++) txBuf[2+i] = 8'h00;
    spiXfer(cnt + 2);
  endtask

  task automatic writeRegs(input int start, input int cnt, input logic [7:0] seed);
    txBuf[0] = 8'h40 | 8'(start);
    txBuf[1] = 8'(cnt - 1);
    for (int i = 0; i < cnt; i++) txBuf[2+i] = 8'((i * 37) ^ seed);
    spiXfer(cnt + 2);
  endtask

  function automatic logic [7:0] frameExp(input int b, input int n);
    int j;
    if (b == 0) return 8'hC0;
    if (b < 3 || b >= 27) return 8'h00;
    j = b - 3;
    case (j % 3)
      0:       return 8'(j / 3);
      1:       return 8'(n >> 8);
      default: return 8'(n);
    endcase
  endfunction

  task automatic checkAllRegs(input string req);
    readRegs(0, NREG);
    for (int a = 0; a < NREG; a++) check(req, rxBuf[2+a], expReg[a]);
  endtask

  task automatic waitReady(output int t);
    int lim = 0;
    while (dataReadyN !== 1'b0 && lim < 3*DIV) begin
      @(negedge clk);
      lim++;
    end
    t = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int t0, t1, t2, lows;
    for (int a = 0; a < 32; a++) expReg[a] = (a < NREG) ? 8'(8'hA0 + a) : 8'h00;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 ready idle", dataReadyN, 1'b1);
    check("R1 miso idle", miso, 1'b0);

    // R1/R2/R5 single-register sweep over every address
    for (int a = 0; a < 32; a++) begin
      readRegs(a, 1);
      if (a == 0) begin
        check("R2 opcode byte", rxBuf[0], 8'h00);
        check("R2 count byte", rxBuf[1], 8'h00);
      end
      if (a < NREG) check("R1 default value", rxBuf[2], expReg[a]);
      else          check("R5 empty read", rxBuf[2], 8'h00);
    end

    // R3 burst write of the whole file, R4 burst read back
    writeRegs(0, NREG, 8'h5A);
    for (int a = 0; a < NREG; a++) expReg[a] = 8'((a * 37) ^ 8'h5A);
    checkAllRegs("R3 burst write");
    readRegs(3, 10);
    for (int i = 0; i < 10; i++) check("R4 mid burst read", rxBuf[2+i], expReg[3+i]);
    txBuf[0] = 8'h27; txBuf[1] = 8'h01;
    for (int i = 2; i < 6; i++) txBuf[i] = 8'h00;
    spiXfer(6);
    check("R4 first", rxBuf[2], expReg[7]);
    check("R4 second", rxBuf[3], expReg[8]);
    check("R4 past count", rxBuf[4], 8'h00);
    check("R4 past count", rxBuf[5], 8'h00);

    // R5 write straddling the end of the file
    writeRegs(24, 4, 8'h33);
    expReg[24] = 8'h33;
    expReg[25] = 8'((37) ^ 8'h33);
    readRegs(24, 4);
    check("R5 in range 24", rxBuf[2], expReg[24]);
    check("R5 in range 25", rxBuf[3], expReg[25]);
    check("R5 dropped 26", rxBuf[4], 8'h00);
    check("R5 dropped 27", rxBuf[5], 8'h00);

    // R12 unknown opcodes with write-like trailing bytes
    begin
      logic [7:0] junk [6] = '{8'h00, 8'h08, 8'h60, 8'h80, 8'hFF, 8'h12};
      for (int k = 0; k < 6; k++) begin
        txBuf[0] = junk[k]; txBuf[1] = 8'h00; txBuf[2] = 8'hEE;
        spiXfer(3);
        check("R12 no reply", rxBuf[2], 8'h00);
      end
    end
    checkAllRegs("R12 regs untouched");
    check("R12 ready idle", dataReadyN, 1'b1);

    // R6 register reset opcode
    sendOp(8'h06);
    for (int a = 0; a < NREG; a++) expReg[a] = 8'(8'hA0 + a);
    checkAllRegs("R6 defaults restored");

    // R7/R8/R9 streaming
    sendOp(8'h10);
    t0 = cyc;
    check("R7 ready high after start", dataReadyN, 1'b1);
    waitReady(t1);
    check("R7 first fall window", ((t1 - t0) <= DIV) && ((t1 - t0) >= DIV - 60), 1'b1);
    for (int i = 0; i < 28; i++) txBuf[i] = 8'h00;
    spiXfer(28);
    check("R8 low before edge", drdyBefore, 1'b0);
    check("R8 high after edge", drdyAfter, 1'b1);
    for (int b = 0; b < 28; b++) check("R9 frame 1", rxBuf[b], frameExp(b, 1));
    waitReady(t2);
    check("R7 period", t2 - t1, DIV);
    spiXfer(28);
    for (int b = 0; b < 28; b++) check("R9 frame 2", rxBuf[b], frameExp(b, 2));

    // R10 register write ignored while streaming, then stop
    txBuf[0] = 8'h45; txBuf[1] = 8'h00; txBuf[2] = 8'h99;
    spiXfer(3);
    txBuf[0] = 8'h11;
    spiXfer(1);
    lows = 0;
    for (int i = 0; i < 2*DIV + 100; i++) begin
      @(negedge clk);
      if (dataReadyN !== 1'b1) lows++;
    end
    check("R10 ready stays high", lows, 0);
    readRegs(5, 1);
    check("R10 stream write ignored", rxBuf[2], 8'hA5);

    // R11 standby and wakeup latencies
    sendOp(8'h04);
    sendOp(8'h02);              // ignored: still entering standby
    repeat (SLP + 100) @(negedge clk);
    writeRegs(2, 1, 8'h11);     // ignored: asleep
    readRegs(2, 1);
    check("R11 asleep read silent", rxBuf[2], 8'h00);
    sendOp(8'h02);
    writeRegs(2, 1, 8'h22);     // ignored: waking
    repeat (WAK + 100) @(negedge clk);
    writeRegs(3, 1, 8'h33);
    readRegs(2, 2);
    check("R11 writes ignored around standby", rxBuf[2], 8'hA2);
    check("R11 write after wake", rxBuf[3], 8'h33);

    finishRun();
  end
endmodule